// File: doc/BRIEF.md
# Sub-cycle Digital PWM Generator with Dead-Time Insertion

This block drives the two power switches of one synchronous buck phase. It takes an on-time command and produces a high-side gate level and a low-side gate level, with a guard interval between them at every switching edge. Every duration is counted in sixteenths of a clock period. A coarse counter places each edge in a whole clock cycle. A 4-bit tap value is registered with each edge so that an external delay line can move the edge by the remaining fraction of a cycle.

The command is first limited to a programmed window. After that it is raised to at least one clock cycle. Two run styles exist. In the continuous style, a period counter restarts the switching pattern every `cfg_period` cycles. In the single-shot style, each trigger pulse runs exactly one high-then-low sequence. Both switches then stay open until the next trigger, so the inductor current cannot reverse.

All outputs are registered. The level shown in a cycle comes from the counter value of the previous cycle.

Top module: `dpwm_deadtime`

## Requirements
- R1: `hs_gate` and `ls_gate` are never high in the same cycle. When one gate rises in the same cycle in which the other falls, the tap of the rising gate is strictly larger than the tap of the falling gate.
- R2: The effective on-time is computed as follows: the command is limited to at most `cfg_ton_max`, then raised to at least `cfg_ton_min`, then raised to at least 16 sixteenths. The high-side gate stays high for exactly that effective on-time.
- R3: Dead times are in sixteenths, and a value of 0 is used as 1. The high-side gate rises `cfg_dead_lh` after the start of a cycle. The low-side gate rises `cfg_dead_hl` after the high-side gate falls.
- R4: An edge at time t sixteenths after the start falls in the whole cycle floor(t/16). The tap output of that gate takes t mod 16 (bits 3:0 of t) in the cycle of the edge. The tap output is unchanged in every cycle without an edge on its gate. An edge that is not scheduled (period wrap, reset) carries tap 0.
- R5: In continuous mode (`cfg_mode`=0) the pattern repeats every `cfg_period` clock cycles. The low-side gate stays high until the period ends, then falls at tap 0.
- R6: `ton_cmd` and the timing settings are captured only when a period or shot starts. A change during a pulse does not shorten or extend that pulse.
- R7: In single-shot mode (`cfg_mode`=1), one trigger runs the high-side on-time, then keeps the low-side gate high for `cfg_ls_on` (raised to at least 16). After that both gates stay low. With no trigger, both gates stay low.
- R8: A trigger that arrives while a single shot is still running is ignored.
- R9: A synchronous active-high `rst` drives both gates and both tap outputs to 0 on the next edge and returns the block to idle.
- R10: `cfg_mode` is read only at a period boundary or while idle. A switch to single-shot mode lets the running period finish, and the block then stays quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 1 | 0 = continuous, 1 = single-shot |
| cfg_period | input | CW | Period length in clock cycles |
| cfg_ton_min | input | CW+FW | Lower on-time limit, sixteenths |
| cfg_ton_max | input | CW+FW | Upper on-time limit, sixteenths |
| cfg_dead_lh | input | CW+FW | Guard time before the high-side rise, sixteenths |
| cfg_dead_hl | input | CW+FW | Guard time before the low-side rise, sixteenths |
| cfg_ls_on | input | CW+FW | Low-side on-time in single-shot mode, sixteenths |
| ton_cmd | input | CW+FW | Commanded on-time, sixteenths |
| pfm_trig | input | 1 | Single-shot start pulse |
| hs_gate | output | 1 | High-side gate level |
| ls_gate | output | 1 | Low-side gate level |
| hs_tap | output | FW | Sub-cycle tap for the latest high-side edge |
| ls_tap | output | FW | Sub-cycle tap for the latest low-side edge |

## Verification
The bench aims at the clamp boundaries: a command above the maximum, one below the minimum, one below a single cycle, and a minimum set above the maximum. A design that took the limits in the wrong order, or that left out the one-cycle floor, would give a wrong high-side cycle count. Zero dead times and edges that share one coarse cycle test the tap ordering; a wrong carry into the coarse count would show up as a misplaced tap or as overlapping gates. An on-time change in the middle of a pulse, a second trigger during a shot, a mode change in mid-period and a reset in mid-pulse would each show a design that samples too early, restarts, or leaves a gate hanging high.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef enum logic {MODE_PWM = 1'b0, MODE_PFM = 1'b1} mode_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} state_e;
  // edge slots in the schedule vector
  localparam int E_HS_ON  = 0;
  localparam int E_HS_OFF = 1;
  localparam int E_LS_ON  = 2;
  localparam int E_LS_OFF = 3;
  localparam int N_EDGES  = 4;
endpackage

// File: rtl/dpwm_clamp.sv
module dpwm_clamp #(
  parameter int DW    = 14,
  parameter int FLOOR = 16
) (
  input  logic [DW-1:0] cmd,
  input  logic [DW-1:0] lim_min,
  input  logic [DW-1:0] lim_max,
  output logic [DW-1:0] ton
);
  logic [DW-1:0] hi_cut, lo_cut;
  always_comb begin
    hi_cut = (cmd > lim_max) ? lim_max : cmd;
    lo_cut = (hi_cut < lim_min) ? lim_min : hi_cut;
    ton    = (lo_cut < DW'(FLOOR)) ? DW'(FLOOR) : lo_cut;
  end
endmodule

// File: rtl/dpwm_edge_sched.sv
module dpwm_edge_sched
  import dpwm_pkg::*;
#(
  parameter int DW  = 14,
  parameter int FW  = 4,
  parameter int TW  = DW + 2,
  parameter int CTW = TW - FW
) (
  input  logic [DW-1:0]                  ton,
  input  logic [DW-1:0]                  dead_lh,
  input  logic [DW-1:0]                  dead_hl,
  input  logic [DW-1:0]                  ls_on,
  output logic [N_EDGES-1:0][CTW-1:0]    ecoarse,
  output logic [N_EDGES-1:0][FW-1:0]     efine
);
  localparam int ONE_CYC = 1 << FW;
  logic [DW-1:0] dlh, dhl, lso;
  logic [N_EDGES-1:0][TW-1:0] etime;

  always_comb begin
    dlh = (dead_lh == '0) ? DW'(1) : dead_lh;
    dhl = (dead_hl == '0) ? DW'(1) : dead_hl;
    lso = (ls_on < DW'(ONE_CYC)) ? DW'(ONE_CYC) : ls_on;
    etime[E_HS_ON]  = TW'(dlh);
    etime[E_HS_OFF] = etime[E_HS_ON]  + TW'(ton);
    etime[E_LS_ON]  = etime[E_HS_OFF] + TW'(dhl);
    etime[E_LS_OFF] = etime[E_LS_ON]  + TW'(lso);
  end

  for (genvar i = 0; i < N_EDGES; i++) begin : g_split
    assign ecoarse[i] = etime[i][TW-1:FW];
    assign efine[i]   = etime[i][FW-1:0];
  end
endmodule

// File: rtl/dpwm_seq.sv
module dpwm_seq
  import dpwm_pkg::*;
#(
  parameter int CW  = 10,
  parameter int CTW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_mode,
  input  logic [CW-1:0]  period,
  input  logic           trig,
  input  logic [CTW-1:0] end_c,
  output logic           start,
  output logic           run,
  output mode_e          mode_l,
  output logic [CTW-1:0] cnt
);
  state_e       st;
  logic [CTW:0] cnt_nxt;
  logic         last_pwm, idle_go, wrap_go, stop;

  always_comb begin
    cnt_nxt  = {1'b0, cnt} + 1'b1;
    last_pwm = cnt_nxt >= (CTW+1)'(period);
    idle_go  = (st == ST_IDLE) && ((cfg_mode == MODE_PWM) || trig);
    wrap_go  = (st == ST_RUN) && (mode_l == MODE_PWM) && last_pwm && (cfg_mode == MODE_PWM);
    start    = idle_go || wrap_go;
    stop     = (st == ST_RUN) &&
               (((mode_l == MODE_PWM) && last_pwm && (cfg_mode == MODE_PFM)) ||
                ((mode_l == MODE_PFM) && (cnt == end_c)));
  end

  assign run = (st == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      mode_l <= MODE_PWM;
    end else if (start) begin
      st     <= ST_RUN;
      cnt    <= '0;
      mode_l <= mode_e'(cfg_mode);
    end else if (stop) begin
      st     <= ST_IDLE;
      cnt    <= '0;
    end else if (st == ST_RUN) begin
      cnt    <= cnt_nxt[CTW-1:0];
    end
  end
endmodule

// File: rtl/dpwm_deadtime.sv
module dpwm_deadtime
  import dpwm_pkg::*;
#(
  parameter int CW = 10,
  parameter int FW = 4,
  parameter int DW = CW + FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_mode,
  input  logic [CW-1:0] cfg_period,
  input  logic [DW-1:0] cfg_ton_min,
  input  logic [DW-1:0] cfg_ton_max,
  input  logic [DW-1:0] cfg_dead_lh,
  input  logic [DW-1:0] cfg_dead_hl,
  input  logic [DW-1:0] cfg_ls_on,
  input  logic [DW-1:0] ton_cmd,
  input  logic          pfm_trig,
  output logic          hs_gate,
  output logic          ls_gate,
  output logic [FW-1:0] hs_tap,
  output logic [FW-1:0] ls_tap
);
  localparam int TW      = DW + 2;
  localparam int CTW     = TW - FW;
  localparam int ONE_CYC = 1 << FW;

  logic [DW-1:0] ton_cl;
  logic [DW-1:0] ton_q, dlh_q, dhl_q, ls_q;
  logic [N_EDGES-1:0][CTW-1:0] ec;
  logic [N_EDGES-1:0][FW-1:0]  ef;
  logic           start, run;
  mode_e          mode_l;
  logic [CTW-1:0] cnt, end_c;
  logic           mode_pfm;
  logic           hs_n, ls_n;
  logic [FW-1:0]  hs_tap_n, ls_tap_n;

  dpwm_clamp #(.DW(DW), .FLOOR(ONE_CYC)) u_clamp (
    .cmd(ton_cmd), .lim_min(cfg_ton_min), .lim_max(cfg_ton_max), .ton(ton_cl)
  );

  // shadow set: captured only when a period or shot begins
  always_ff @(posedge clk) begin
    if (rst) begin
      ton_q <= '0; dlh_q <= '0; dhl_q <= '0; ls_q <= '0;
    end else if (start) begin
      ton_q <= ton_cl;
      dlh_q <= cfg_dead_lh;
      dhl_q <= cfg_dead_hl;
      ls_q  <= cfg_ls_on;
    end
  end

  dpwm_edge_sched #(.DW(DW), .FW(FW), .TW(TW), .CTW(CTW)) u_sched (
    .ton(ton_q), .dead_lh(dlh_q), .dead_hl(dhl_q), .ls_on(ls_q),
    .ecoarse(ec), .efine(ef)
  );

  assign end_c    = ec[E_LS_OFF];
  assign mode_pfm = (mode_l == MODE_PFM);

  dpwm_seq #(.CW(CW), .CTW(CTW)) u_seq (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .period(cfg_period),
    .trig(pfm_trig), .end_c(end_c), .start(start), .run(run),
    .mode_l(mode_l), .cnt(cnt)
  );

  always_comb begin
    hs_n = run && (cnt >= ec[E_HS_ON]) && (cnt < ec[E_HS_OFF]);
    ls_n = run && (cnt >= ec[E_LS_ON]) && (!mode_pfm || (cnt < ec[E_LS_OFF]));
    hs_tap_n = hs_tap;
    if (hs_n && !hs_gate)
      hs_tap_n = ef[E_HS_ON];
    else if (!hs_n && hs_gate)
      hs_tap_n = (run && cnt == ec[E_HS_OFF]) ? ef[E_HS_OFF] : '0;
    ls_tap_n = ls_tap;
    if (ls_n && !ls_gate)
      ls_tap_n = ef[E_LS_ON];
    else if (!ls_n && ls_gate)
      ls_tap_n = (run && mode_pfm && cnt == ec[E_LS_OFF]) ? ef[E_LS_OFF] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_gate <= 1'b0; ls_gate <= 1'b0; hs_tap <= '0; ls_tap <= '0;
    end else begin
      hs_gate <= hs_n; ls_gate <= ls_n; hs_tap <= hs_tap_n; ls_tap <= ls_tap_n;
    end
  end
endmodule

// File: rtl/dpwm_chk.sv
module dpwm_chk #(
  parameter int CTW = 12,
  parameter int FW  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           hs_gate,
  input logic           ls_gate,
  input logic [FW-1:0]  hs_tap,
  input logic [FW-1:0]  ls_tap,
  input logic           run,
  input logic           mode_pfm,
  input logic           pfm_trig,
  input logic [CTW-1:0] cnt,
  input logic [CTW-1:0] end_c
);
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate));

  a_r1_hs_after_ls: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(hs_gate) && $fell(ls_gate)) |-> (hs_tap > ls_tap));

  a_r1_ls_after_hs: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(ls_gate) && $fell(hs_gate)) |-> (ls_tap > hs_tap));

  a_r4_tap_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(hs_gate) && $stable(ls_gate)) |-> ($stable(hs_tap) && $stable(ls_tap)));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!hs_gate && !ls_gate));

  a_r8_trig_ignored: assert property (@(posedge clk) disable iff (rst)
    (run && mode_pfm && pfm_trig && cnt != end_c) |=> (cnt == $past(cnt) + CTW'(1)));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!hs_gate && !ls_gate && hs_tap == '0 && ls_tap == '0));
endmodule

bind dpwm_deadtime dpwm_chk #(.CTW(CTW), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .hs_gate(hs_gate), .ls_gate(ls_gate),
  .hs_tap(hs_tap), .ls_tap(ls_tap), .run(run), .mode_pfm(mode_pfm),
  .pfm_trig(pfm_trig), .cnt(cnt), .end_c(end_c)
);

// File: tb/dpwm_deadtime_tb.sv
module dpwm_deadtime_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10, FW = 4, DW = CW + FW;
  localparam int NV = 5;
  // cmd, min, max, dead_lh, dead_hl, period, exp_hs_cycles, exp_ls_cycles, exp_rise_tap, exp_fall_tap, exp_ls_rise_tap
  localparam int VEC [NV][11] = '{
    '{100,  32, 200,  5,  7, 20,  6, 13, 5,  9,  0},
    '{500,  32, 200, 20,  3, 20, 12,  7, 4, 12, 15},
    '{ 10,  40, 300,  0,  0, 20,  2, 18, 1,  9, 10},
    '{  8,   0, 300, 16, 17, 20,  1, 17, 0,  0,  1},
    '{120, 150, 100,  2,  2, 20,  9, 11, 2,  8, 10}
  };

  logic clk = 1'b0, rst = 1'b1, cfg_mode = 1'b0, pfm_trig = 1'b0;
  logic [CW-1:0] cfg_period = 10'd20;
  logic [DW-1:0] cfg_ton_min = '0, cfg_ton_max = '0, cfg_dead_lh = '0, cfg_dead_hl = '0;
  logic [DW-1:0] cfg_ls_on = '0, ton_cmd = '0;
  logic hs_gate, ls_gate;
  logic [FW-1:0] hs_tap, ls_tap;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int m_hs, m_ls, m_rise, m_fall, m_lsrise, m_lsfall, m_hsrises, m_ovl;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpwm_deadtime #(.CW(CW), .FW(FW)) u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_period(cfg_period),
    .cfg_ton_min(cfg_ton_min), .cfg_ton_max(cfg_ton_max),
    .cfg_dead_lh(cfg_dead_lh), .cfg_dead_hl(cfg_dead_hl), .cfg_ls_on(cfg_ls_on),
    .ton_cmd(ton_cmd), .pfm_trig(pfm_trig), .hs_gate(hs_gate), .ls_gate(ls_gate),
    .hs_tap(hs_tap), .ls_tap(ls_tap)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_rise();
    logic p;
    int guard = 0;
    p = hs_gate;
    @(negedge clk);
    while (!(hs_gate && !p) && guard < 500) begin
      p = hs_gate; @(negedge clk); guard++;
    end
  endtask

  // observe win cycles starting with the current one
  task automatic observe(input int win);
    logic ph, pl;
    m_hs = 0; m_ls = 0; m_fall = -1; m_lsrise = -1; m_lsfall = -1; m_hsrises = 0; m_ovl = 0;
    m_rise = hs_tap; ph = 1'b0; pl = ls_gate;
    for (int i = 0; i < win; i++) begin
      if (i > 0) @(negedge clk);
      if (hs_gate && !ph && i > 0) m_hsrises++;
      if (!hs_gate && ph) m_fall = hs_tap;
      if (ls_gate && !pl) m_lsrise = ls_tap;
      if (!ls_gate && pl) m_lsfall = ls_tap;
      if (hs_gate) m_hs++;
      if (ls_gate) m_ls++;
      if (hs_gate && ls_gate) m_ovl++;
      ph = hs_gate; pl = ls_gate;
    end
  endtask

  task automatic load_vec(input int v);
    ton_cmd = DW'(VEC[v][0]); cfg_ton_min = DW'(VEC[v][1]); cfg_ton_max = DW'(VEC[v][2]);
    cfg_dead_lh = DW'(VEC[v][3]); cfg_dead_hl = DW'(VEC[v][4]); cfg_period = CW'(VEC[v][5]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    // R9: reset state
    repeat (2) @(negedge clk);
    chk("R9 reset hs_gate", hs_gate, 0);
    chk("R9 reset ls_gate", ls_gate, 0);
    chk("R9 reset taps", hs_tap + ls_tap, 0);

    // vector table: continuous mode
    for (int v = 0; v < NV; v++) begin
      cfg_mode = 1'b0; load_vec(v);
      do_reset();
      wait_rise();
      observe(VEC[v][5]);
      chk("R2 high-side cycles", m_hs, VEC[v][6]);
      chk("R5 low-side cycles per period", m_ls, VEC[v][7]);
      chk("R3 high-side rise tap", m_rise, VEC[v][8]);
      chk("R4 high-side fall tap", m_fall, VEC[v][9]);
      chk("R3 low-side rise tap", m_lsrise, VEC[v][10]);
      chk("R1 overlap cycles", m_ovl, 0);
    end

    // R5: period wrap drops low side at tap 0 and next pattern repeats
    load_vec(0); do_reset();
    wait_rise(); observe(20);
    wait_rise(); chk("R5 low-side fall tap at wrap", ls_tap, 0);
    observe(20);
    chk("R5 second period high-side cycles", m_hs, 6);

    // R6: command change mid-pulse
    load_vec(0); do_reset();
    wait_rise();
    ton_cmd = DW'(200);
    n = 0;
    while (hs_gate && n < 100) begin n++; @(negedge clk); end
    chk("R6 running pulse kept", n, 6);
    wait_rise(); observe(20);
    chk("R6 next period new on-time", m_hs, 12);
    chk("R6 next period fall tap", m_fall, 13);

    // R9: reset in mid-pulse
    load_vec(0); do_reset();
    wait_rise(); @(negedge clk);
    rst = 1'b1; @(negedge clk);
    chk("R9 mid-pulse reset hs", hs_gate, 0);
    chk("R9 mid-pulse reset ls", ls_gate, 0);
    chk("R9 mid-pulse reset tap", hs_tap, 0);
    rst = 1'b0;

    // R10: switch to single-shot during a period
    load_vec(0); do_reset();
    wait_rise(); cfg_mode = 1'b1;
    repeat (25) @(negedge clk);
    observe(30);
    chk("R10 quiet after mode switch", m_hs + m_ls, 0);

    // R7: single-shot
    load_vec(0); cfg_mode = 1'b1; cfg_ls_on = DW'(50);
    do_reset();
    observe(30);
    chk("R7 no trigger no switching", m_hs + m_ls, 0);
    pfm_trig = 1'b1; @(negedge clk); pfm_trig = 1'b0;
    observe(40);
    chk("R7 shot high-side cycles", m_hs, 6);
    chk("R7 shot low-side cycles", m_ls, 3);
    chk("R7 shot low-side fall tap", m_lsfall, 2);
    chk("R7 low side stays off", ls_gate, 0);

    // R8: second trigger while shot runs
    pfm_trig = 1'b1; @(negedge clk); pfm_trig = 1'b0;
    repeat (3) @(negedge clk);
    pfm_trig = 1'b1; @(negedge clk); pfm_trig = 1'b0;
    observe(40);
    chk("R8 single rise only", m_hsrises, 0);
    chk("R8 high-side cycles unchanged", m_hs, 3);

    // R7: low-side time floor of one cycle
    cfg_dead_hl = DW'(10); cfg_ls_on = DW'(3);
    pfm_trig = 1'b1; @(negedge clk); pfm_trig = 1'b0;
    observe(40);
    chk("R7 floored low-side cycles", m_ls, 1);
    chk("R7 floored low-side fall tap", m_lsfall, 3);
    chk("R1 overlap in shots", m_ovl, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule